// File: doc/BRIEF.md
# Retrying Transmit Frame Buffer Controller

This block sits between a host and a bit-level serial bus transmitter in a data link layer. The host writes bytes into an eleven-entry buffer, and a three-bit command comes with each byte. The controller decides when a frame may go out. It hands the bytes one at a time to the transmitter and closes each attempt with a CRC-8 byte. It reports the result of every attempt as a two-bit completion code.

A frame stays in the buffer until it is sent successfully. After lost arbitration, a transmit error or an underrun, the controller returns to the first byte and tries again as soon as the bus is idle. The host stops this loop with a terminate command, or it discards the frame with a clear command. A frame is either loaded whole and closed by a last-tagged byte, or it is streamed without that tag. A streamed frame starts once the buffer is full.

Top module: `txbuf_retry_ctrl`

## Requirements
- R1: After reset, `buf_full`, `tx_valid` and `cc_valid` are low and the buffer is empty.
- R2: A transmission starts only when the buffer holds a complete frame or is full, and the bus is reported idle. A complete frame is one whose last byte came with command 2. Before that, `tx_valid` stays low.
- R3: Host commands 0 (first) and 1 (middle) append the data byte, and command 2 (last) appends it and marks the frame complete. The buffered bytes go out in write order. The final byte of the attempt is the ones complement of the CRC-8 remainder, with polynomial 0x1D, initial value 0xFF and MSB first, taken over the data bytes.
- R4: When the transmitter takes a good CRC byte, `cc_valid` pulses with code 0 (success), the buffer is released and `buf_full` falls.
- R5: While a complete or full frame is held, `buf_full` stays high until that frame is released.
- R6: `arb_lost` during an attempt ends it with code 1. The frame is then replayed from its first byte with identical bytes.
- R7: `tx_err` during an attempt ends it with code 2, and the frame is replayed from its first byte.
- R8: Command 5 (terminate retry) issued during an attempt lets that attempt end. Then, whatever the outcome, the buffer is cleared and nothing is replayed.
- R9: Command 5 issued while a frame waits for an idle bus gives exactly one attempt, and then the buffer is cleared.
- R10: Command 3 discards the buffer at once. Command 4 discards it and stores its data byte as the first byte of a new frame.
- R11: If a frame that is not complete runs out of bytes mid-transmission, the raw remainder goes out instead of its complement. The attempt ends with code 3 (underrun) and is replayed.
- R12: Data writes to a full buffer are dropped. A last-tagged write to a full buffer still marks the frame complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_valid | input | 1 | Host command strobe |
| host_cmd | input | 3 | 0 first, 1 middle, 2 last, 3 clear, 4 clear+first, 5 terminate retry |
| host_data | input | 8 | Data byte accompanying the command |
| buf_full | output | 1 | Buffer holds a complete frame or is full |
| bus_idle | input | 1 | Bus is idle, so a frame may start |
| tx_valid | output | 1 | A byte is offered to the transmitter |
| tx_byte | output | 8 | Offered byte |
| tx_take | input | 1 | Transmitter consumes the offered byte |
| arb_lost | input | 1 | Arbitration lost during the attempt |
| tx_err | input | 1 | Transmit error during the attempt |
| cc_valid | output | 1 | One-cycle completion code strobe |
| cc_code | output | 2 | 0 success, 1 arbitration lost, 2 error, 3 underrun |

## Verification
The frame path is tried with frames of one to eleven bytes built from several data seeds. Each is loaded whole with a last tag, so any wrong byte order or CRC shows up against the bench's own CRC. The same frames are then interrupted in four ways: lost arbitration mid-data, an error on the CRC byte, a terminate before or during the attempt, and a clear. The interruptions tell a replay apart from a release. An untagged eleven-byte stream separates the underrun case, which sends the raw remainder, from the case where a late last tag restores a good CRC.

// File: rtl/txbuf_retry_ctrl.sv
module txbuf_retry_ctrl #(
  parameter int DEPTH = 11
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       host_valid,
  input  logic [2:0] host_cmd,
  input  logic [7:0] host_data,
  output logic       buf_full,
  input  logic       bus_idle,
  output logic       tx_valid,
  output logic [7:0] tx_byte,
  input  logic       tx_take,
  input  logic       arb_lost,
  input  logic       tx_err,
  output logic       cc_valid,
  output logic [1:0] cc_code
);
  localparam int PW = $clog2(DEPTH + 1);
  localparam logic [PW-1:0] FULL_CNT = PW'(DEPTH);

  typedef enum logic [1:0] {S_IDLE, S_DATA, S_CRC} st_t;
  st_t state;

  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] cnt, rd_ptr;
  logic          complete, term, bad;
  logic [7:0]    crc;

  function automatic logic [7:0] crc_step(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r;
    r = c ^ d;
    for (int i = 0; i < 8; i++) r = r[7] ? ((r << 1) ^ 8'h1D) : (r << 1);
    return r;
  endfunction

  wire is_clr   = host_valid && (host_cmd == 3'd3 || host_cmd == 3'd4);
  wire is_data  = host_valid && host_cmd <= 3'd2;
  wire can_wr   = is_data && !complete && cnt != FULL_CNT;
  wire fail     = (state != S_IDLE) && (arb_lost || tx_err);
  wire fin      = (state == S_CRC) && tx_take && !fail;
  wire outcome  = fail || fin;
  wire release_ = (fin && !bad) || (outcome && term);
  wire [1:0] code = arb_lost ? 2'd1 : tx_err ? 2'd2 : bad ? 2'd3 : 2'd0;

  assign buf_full = complete || cnt == FULL_CNT;
  assign tx_valid = (state == S_CRC) || (state == S_DATA && rd_ptr != cnt);
  assign tx_byte  = (state == S_CRC) ? (bad ? crc : ~crc) : mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (is_clr && host_cmd == 3'd4) mem[0] <= host_data;
    else if (!is_clr && can_wr) mem[cnt] <= host_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE; cnt <= '0; rd_ptr <= '0; complete <= 1'b0;
      term <= 1'b0; bad <= 1'b0; crc <= 8'hFF; cc_valid <= 1'b0; cc_code <= 2'd0;
    end else begin
      cc_valid <= 1'b0;
      if (is_clr) begin
        cnt <= (host_cmd == 3'd4) ? PW'(1) : '0;
        complete <= 1'b0; term <= 1'b0; bad <= 1'b0;
        rd_ptr <= '0; crc <= 8'hFF; state <= S_IDLE;
      end else begin
        if (can_wr) cnt <= cnt + 1'b1;
        if (is_data && host_cmd == 3'd2) complete <= 1'b1;
        if (host_valid && host_cmd == 3'd5 && cnt != '0) term <= 1'b1;
        case (state)
          S_IDLE:
            if (buf_full && bus_idle) begin
              state <= S_DATA; rd_ptr <= '0; crc <= 8'hFF;
            end
          S_DATA:
            if (!fail) begin
              if (rd_ptr == cnt) begin
                state <= S_CRC; bad <= !complete;
              end else if (tx_take) begin
                rd_ptr <= rd_ptr + 1'b1;
                crc <= crc_step(crc, tx_byte);
              end
            end
          default: ;
        endcase
        if (outcome) begin
          cc_valid <= 1'b1; cc_code <= code;
          state <= S_IDLE; rd_ptr <= '0; crc <= 8'hFF; bad <= 1'b0;
          if (release_) begin
            cnt <= '0; complete <= 1'b0; term <= 1'b0;
          end
        end
      end
    end
  end

  assert_start_gate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(state != S_IDLE) |-> $past(bus_idle && buf_full));
  assert_success_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cc_valid && cc_code == 2'd0) |-> (cnt == '0 && !complete));
  assert_full_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_full && !is_clr && !release_) |=> buf_full);
  assert_arb_code_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cc_valid && cc_code == 2'd1) |-> $past(arb_lost));
  assert_replay_from_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cc_valid && cc_code != 2'd0) |-> (rd_ptr == '0 && state == S_IDLE));
  assert_no_overflow_R12: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= FULL_CNT);
endmodule

// File: tb/txbuf_retry_ctrl_bench.sv
module txbuf_retry_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] VEC [6] = '{16'h0100, 16'h0211, 16'h0347, 16'h05A5, 16'h08F0, 16'h0B3C};

  logic clk = 0, rst_n = 0, host_valid = 0, bus_idle = 0, tx_take = 0, arb_lost = 0, tx_err = 0;
  logic [2:0] host_cmd = 0;
  logic [7:0] host_data = 0, tx_byte;
  logic buf_full, tx_valid, cc_valid;
  logic [1:0] cc_code;
  int total = 0, fails = 0, cc_cnt = 0;
  logic [1:0] cc_last = 0;
  logic [7:0] exp_b [16];
  logic [7:0] got;

  txbuf_retry_ctrl u_txbuf_retry_ctrl (.clk, .rst_n, .host_valid, .host_cmd, .host_data, .buf_full,
    .bus_idle, .tx_valid, .tx_byte, .tx_take, .arb_lost, .tx_err, .cc_valid, .cc_code);

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) begin #2; if (cc_valid) begin cc_cnt++; cc_last = cc_code; end end

  initial begin
    repeat (100000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: run did not end, got timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  function automatic logic [7:0] crc8(input int n);
    logic [7:0] c = 8'hFF;
    for (int i = 0; i < n; i++) begin
      c ^= exp_b[i];
      for (int k = 0; k < 8; k++) c = c[7] ? ((c << 1) ^ 8'h1D) : (c << 1);
    end
    return c;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic wr(input logic [2:0] c, input logic [7:0] d);
    host_valid = 1; host_cmd = c; host_data = d;
    @(negedge clk); host_valid = 0;
  endtask

  task automatic load(input int n, input logic [7:0] seed);
    for (int i = 0; i < n; i++) begin
      exp_b[i] = seed + 8'(i * 59);
      wr((i == n - 1) ? 3'd2 : (i == 0 ? 3'd0 : 3'd1), exp_b[i]);
    end
  endtask

  task automatic wait_valid();
    int t = 0;
    while (!tx_valid && t < 60) begin @(negedge clk); t++; end
  endtask

  task automatic take(output logic [7:0] b);
    wait_valid();
    b = tx_byte; tx_take = 1;
    @(negedge clk); tx_take = 0;
  endtask

  task automatic rx_frame(input string req, input int n, input logic [7:0] crc_exp);
    for (int i = 0; i < n; i++) begin take(got); check(req, got, exp_b[i]); end
    take(got); check(req, got, crc_exp);
  endtask

  task automatic pulse(input bit arb);
    wait_valid();
    if (arb) arb_lost = 1; else tx_err = 1;
    @(negedge clk); arb_lost = 0; tx_err = 0;
  endtask

  task automatic quiet(input string req);
    logic seen = 0;
    repeat (5) begin @(negedge clk); seen |= tx_valid; end
    check(req, seen, 0);
  endtask

  initial begin
    int c0;
    repeat (3) @(negedge clk);
    check("R1 buf_full", buf_full, 0); check("R1 tx_valid", tx_valid, 0); check("R1 cc_valid", cc_valid, 0);
    rst_n = 1; @(negedge clk);

    // R3 R4: frames of several lengths and seeds
    bus_idle = 1;
    for (int v = 0; v < 6; v++) begin
      c0 = cc_cnt;
      load(int'(VEC[v][15:8]), VEC[v][7:0]);
      rx_frame("R3 frame bytes", int'(VEC[v][15:8]), ~crc8(int'(VEC[v][15:8])));
      check("R4 code count", cc_cnt, c0 + 1); check("R4 code", cc_last, 0);
      check("R4 buf released", buf_full, 0);
    end

    // R2: partial frame and busy bus hold transmission
    wr(3'd0, 8'h12); wr(3'd1, 8'h34);
    quiet("R2 partial frame"); check("R2 not full", buf_full, 0);
    bus_idle = 0; wr(3'd2, 8'h56);
    quiet("R2 bus busy"); check("R5 full held", buf_full, 1);
    exp_b[0] = 8'h12; exp_b[1] = 8'h34; exp_b[2] = 8'h56;
    bus_idle = 1;
    take(got); check("R3 first", got, 8'h12); take(got);
    check("R5 full during tx", buf_full, 1);
    c0 = cc_cnt; pulse(1);
    check("R6 arb code", cc_last, 1); check("R6 one code", cc_cnt, c0 + 1); check("R5 kept", buf_full, 1);
    rx_frame("R6 replay", 3, ~crc8(3)); check("R6 then success", cc_last, 0);

    // R7: error on CRC byte, then replay
    load(4, 8'h21);
    for (int i = 0; i < 4; i++) take(got);
    pulse(0); check("R7 err code", cc_last, 2); check("R7 kept", buf_full, 1);
    rx_frame("R7 replay", 4, ~crc8(4)); check("R7 success", cc_last, 0);

    // R8: terminate during attempt
    load(3, 8'h77); take(got);
    wr(3'd5, 8'h00); pulse(1);
    check("R8 code", cc_last, 1); check("R8 cleared", buf_full, 0); quiet("R8 no replay");

    // R9: terminate while waiting for idle bus
    bus_idle = 0; load(2, 8'h90); wr(3'd5, 8'h00); bus_idle = 1;
    take(got); take(got); pulse(0);
    check("R9 code", cc_last, 2); check("R9 cleared", buf_full, 0); quiet("R9 one attempt");

    // R10: clear and clear+first
    bus_idle = 0; load(2, 8'h40); wr(3'd3, 8'h00);
    check("R10 clear", buf_full, 0);
    load(3, 8'h50); wr(3'd4, 8'hC1); wr(3'd2, 8'hC2);
    exp_b[0] = 8'hC1; exp_b[1] = 8'hC2; bus_idle = 1;
    rx_frame("R10 new frame", 2, ~crc8(2)); check("R10 code", cc_last, 0);

    // R11 R12: streamed frame underruns, then late last tag
    for (int i = 0; i < 11; i++) begin exp_b[i] = 8'(i * 17 + 3); wr(3'd1, exp_b[i]); end
    wr(3'd1, 8'hEE);
    rx_frame("R11 raw crc", 11, crc8(11));
    check("R11 underrun code", cc_last, 3); check("R11 kept", buf_full, 1);
    wr(3'd2, 8'hDD);
    rx_frame("R12 drop and complete", 11, ~crc8(11)); check("R12 code", cc_last, 0);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule